// File: doc/BRIEF.md
# Token-Based Selective Replay Tracker

This block follows dependence on loads that are expected to miss in the data cache, so that a late load causes only the instructions that depend on it to be replayed. A small table of saturating counters, indexed by a hash of the program counter, predicts which loads will miss. A load carrying that prediction reaches rename and is given a free token, which makes it the head of that token. Every architectural register has an N-bit token vector. The vector written for a destination is the bitwise OR of the vectors of its two sources, plus the bit of the token the instruction owns, if it owns one.

When a token head completes, the block broadcasts the token one cycle later. If the head came back on time, the broadcast is a clear. If it came back late, the broadcast is a replay, and it names every architectural register whose vector held that bit. In both cases the bit is then removed from every vector and the token goes back to the pool. A load that completes late without a token cannot be tracked, so the block raises a squash pulse instead. The scheduler uses that pulse to remove and reinsert all younger instructions.

A four-state machine drives the broadcast outputs. Its state always reflects the completion seen in the previous cycle:
- IDLE: no event, all outputs quiet.
- CLEAR: a head completed on time.
- REPLAY: a head completed late.
- SQUASH: a load completed late with no token.

Every completion picks the next state from any state. A head completing with the late flag low goes to CLEAR. A head completing with the late flag high goes to REPLAY. A late load without a token goes to SQUASH. Any other cycle goes to IDLE.

Top module: `tok_replay_tracker`

## Requirements
- R1: After reset every register's token vector is zero and all tokens are free. `bc_valid_o` and `squash_o` are low, and every counter of the miss predictor is at the weak-hit value 1, so `pred_miss_o` is 0.
- R2: Each counter is 2 bits wide and indexed by the XOR of the 4-bit groups of the PC (with the default sizes). When a load completes, its counter moves up by one if the load was late and down by one otherwise. Counters saturate at 3 and 0. `pred_miss_o` equals bit 1 of the counter selected by `pred_pc_i`, without a clock delay.
- R3: A valid rename with `ren_flag_i` high is given the lowest-numbered free token (`ren_tok_ok_o`=1, `ren_tok_id_o`=id). When no token is free, `ren_tok_ok_o` is 0 and the instruction owns no bit.
- R4: `ren_vec_o` is the OR of the vectors of both sources, plus bit `ren_tok_id_o` when a token is granted. When `ren_dst_we_i` is high, this value becomes the destination's vector at the clock edge.
- R5: A completion with a token and `cmp_late_i`=0 gives, in the next cycle, `bc_valid_o`=1, `bc_replay_o`=0, and `bc_mask_o` one-hot at the token id. From then on, no register vector holds that bit.
- R6: A completion with a token and `cmp_late_i`=1 gives, in the next cycle, `bc_valid_o`=1 and `bc_replay_o`=1. `replay_regs_o` has bit r set for each register r whose vector held the token bit in the completion cycle. The bit is then cleared everywhere.
- R7: A late load completing without a token gives a one-cycle `squash_o` pulse in the next cycle, with `bc_valid_o`=0, and leaves all vectors unchanged. An on-time load completing without a token gives no pulse.
- R8: When a rename and a token completion fall in the same cycle, `ren_vec_o` and the vector written both exclude the completing token's bit.
- R9: A token named by a completion is not granted in that same cycle. It can be granted again from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc_i | input | 16 | PC looked up at fetch |
| pred_miss_o | output | 1 | Miss prediction for `pred_pc_i` |
| ren_valid_i | input | 1 | Rename slot valid |
| ren_flag_i | input | 1 | Instruction was predicted to miss |
| ren_src_a_i | input | 4 | First source register |
| ren_src_b_i | input | 4 | Second source register |
| ren_dst_i | input | 4 | Destination register |
| ren_dst_we_i | input | 1 | Instruction writes a destination |
| ren_vec_o | output | 8 | Token vector of the renamed instruction |
| ren_tok_ok_o | output | 1 | A token was granted |
| ren_tok_id_o | output | 3 | Granted token id |
| cmp_valid_i | input | 1 | An instruction completes |
| cmp_is_load_i | input | 1 | Completing instruction is a load |
| cmp_pc_i | input | 16 | PC of the completing instruction |
| cmp_has_tok_i | input | 1 | Completing instruction heads a token |
| cmp_tok_i | input | 3 | Token id it heads |
| cmp_late_i | input | 1 | It took extra latency (missed) |
| bc_valid_o | output | 1 | Token broadcast this cycle |
| bc_replay_o | output | 1 | Broadcast is a replay (1) or a clear (0) |
| bc_mask_o | output | 8 | One-hot broadcast token |
| replay_regs_o | output | 16 | Registers that held the replayed token |
| squash_o | output | 1 | Squash and reinsert all younger instructions |

## Verification
The assertions assume that at most one instruction completes per cycle. They also assume that a completion with `cmp_has_tok_i` set names a token that is currently granted and not yet completed. A token-completion check that no vector still holds the bit would also fail if the same cycle's rename wrote that bit back, so it relies on the rule that a completing token can never be granted in that cycle. The directed stimulus completes only tokens whose grants it has already observed at `ren_tok_id_o`, each one exactly once. It drives a single completion at a time and restarts from reset before each scenario, so the token ownership the bench models always matches the hardware.

// File: rtl/tok_pkg.sv
package tok_pkg;
    parameter int NTOK_DEF  = 8;
    parameter int NREG_DEF  = 16;
    parameter int PCW_DEF   = 16;
    parameter int PDEPTH_DEF = 16;

    typedef enum logic [1:0] {
        BC_IDLE,
        BC_CLEAR,
        BC_REPLAY,
        BC_SQUASH
    } bc_state_t;
endpackage

// File: rtl/tok_miss_pred.sv
module tok_miss_pred #(
    parameter int PCW   = tok_pkg::PCW_DEF,
    parameter int DEPTH = tok_pkg::PDEPTH_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PCW-1:0] look_pc,
    output logic           look_miss,
    input  logic           upd_en,
    input  logic [PCW-1:0] upd_pc,
    input  logic           upd_miss
);
    localparam int IW    = $clog2(DEPTH);
    localparam int NFOLD = PCW / IW;

    logic [1:0]    cnt_q [DEPTH];
    logic [IW-1:0] look_idx;
    logic [IW-1:0] upd_idx;

    always_comb begin
        look_idx = '0;
        upd_idx  = '0;
        for (int k = 0; k < NFOLD; k++) begin
            look_idx = look_idx ^ look_pc[k*IW +: IW];
            upd_idx  = upd_idx  ^ upd_pc[k*IW +: IW];
        end
    end

    assign look_miss = cnt_q[look_idx][1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cnt_q[i] <= 2'b01;
        end else if (upd_en) begin
            if (upd_miss && cnt_q[upd_idx] != 2'b11)
                cnt_q[upd_idx] <= cnt_q[upd_idx] + 2'b01;
            else if (!upd_miss && cnt_q[upd_idx] != 2'b00)
                cnt_q[upd_idx] <= cnt_q[upd_idx] - 2'b01;
        end
    end

    // R2
    cnt_sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && upd_miss |=> cnt_q[$past(upd_idx)] != 2'b00);
    // R2
    cnt_sat_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !upd_miss |=> cnt_q[$past(upd_idx)] != 2'b11);
endmodule

// File: rtl/tok_pool.sv
module tok_pool #(
    parameter int NTOK = tok_pkg::NTOK_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_req,
    output logic                    alloc_ok,
    output logic [$clog2(NTOK)-1:0] alloc_id,
    input  logic                    rel_en,
    input  logic [$clog2(NTOK)-1:0] rel_id
);
    localparam int TW = $clog2(NTOK);

    logic [NTOK-1:0] free_q;
    logic            any_free;
    logic [TW-1:0]   low_id;

    always_comb begin
        any_free = 1'b0;
        low_id   = '0;
        for (int i = NTOK - 1; i >= 0; i--) begin
            if (free_q[i]) begin
                any_free = 1'b1;
                low_id   = i[TW-1:0];
            end
        end
    end

    assign alloc_ok = alloc_req && any_free;
    assign alloc_id = low_id;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= '1;
        end else begin
            for (int i = 0; i < NTOK; i++) begin
                if (rel_en && rel_id == i[TW-1:0])
                    free_q[i] <= 1'b1;
                else if (alloc_ok && low_id == i[TW-1:0])
                    free_q[i] <= 1'b0;
            end
        end
    end

    // R3
    grant_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |=> !free_q[$past(alloc_id)]);
    // R9
    release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |=> free_q[$past(rel_id)]);
endmodule

// File: rtl/tok_vec_table.sv
module tok_vec_table #(
    parameter int NREG = tok_pkg::NREG_DEF,
    parameter int NTOK = tok_pkg::NTOK_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_a,
    input  logic [$clog2(NREG)-1:0] rd_b,
    input  logic                    own_en,
    input  logic [$clog2(NTOK)-1:0] own_id,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic                    clr_en,
    input  logic [$clog2(NTOK)-1:0] clr_id,
    output logic [NTOK-1:0]         merged,
    output logic [NREG-1:0]         hold_regs
);
    localparam int RW = $clog2(NREG);

    logic [NTOK-1:0] tab_q [NREG];
    logic [NTOK-1:0] own_bit;
    logic [NTOK-1:0] clr_bit;
    logic [NTOK-1:0] clr_keep;
    logic [NTOK-1:0] tok_held;

    always_comb begin
        own_bit = '0;
        clr_bit = '0;
        if (own_en) own_bit[own_id] = 1'b1;
        clr_bit[clr_id] = 1'b1;
        clr_keep = clr_en ? ~clr_bit : '1;
        merged   = (tab_q[rd_a] | tab_q[rd_b] | own_bit) & clr_keep;
    end

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_hold
            assign hold_regs[r] = |(tab_q[r] & clr_bit);
        end
    endgenerate

    always_comb begin
        tok_held = '0;
        for (int r = 0; r < NREG; r++) tok_held = tok_held | tab_q[r];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) tab_q[r] <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (wr_en && wr_idx == r[RW-1:0])
                    tab_q[r] <= merged;
                else
                    tab_q[r] <= tab_q[r] & clr_keep;
            end
        end
    end

    // R5
    bit_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !tok_held[$past(clr_id)]);
    // R4
    own_in_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && own_en |=> tab_q[$past(wr_idx)][$past(own_id)]);
endmodule

// File: rtl/tok_bc_fsm.sv
module tok_bc_fsm #(
    parameter int NREG = tok_pkg::NREG_DEF,
    parameter int NTOK = tok_pkg::NTOK_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmp_valid,
    input  logic                    cmp_is_load,
    input  logic                    cmp_has_tok,
    input  logic                    cmp_late,
    input  logic [$clog2(NTOK)-1:0] cmp_tok,
    input  logic [NREG-1:0]         hold_regs,
    output logic                    bc_valid,
    output logic                    bc_replay,
    output logic [NTOK-1:0]         bc_mask,
    output logic [NREG-1:0]         replay_regs,
    output logic                    squash
);
    import tok_pkg::*;
    localparam int TW = $clog2(NTOK);

    bc_state_t       st_q, st_d;
    logic [TW-1:0]   tok_q;
    logic [NREG-1:0] regs_q;

    always_comb begin
        st_d = BC_IDLE;
        if (cmp_valid && cmp_has_tok)
            st_d = cmp_late ? BC_REPLAY : BC_CLEAR;
        else if (cmp_valid && cmp_is_load && cmp_late)
            st_d = BC_SQUASH;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BC_IDLE;
            tok_q  <= '0;
            regs_q <= '0;
        end else begin
            st_q   <= st_d;
            tok_q  <= cmp_tok;
            regs_q <= hold_regs;
        end
    end

    always_comb begin
        bc_valid    = 1'b0;
        bc_replay   = 1'b0;
        bc_mask     = '0;
        replay_regs = '0;
        squash      = 1'b0;
        unique case (st_q)
            BC_IDLE: ;
            BC_CLEAR: begin
                bc_valid       = 1'b1;
                bc_mask[tok_q] = 1'b1;
            end
            BC_REPLAY: begin
                bc_valid       = 1'b1;
                bc_replay      = 1'b1;
                bc_mask[tok_q] = 1'b1;
                replay_regs    = regs_q;
            end
            BC_SQUASH: squash = 1'b1;
            default: ;
        endcase
    end

    // R5
    clear_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_has_tok && !cmp_late |=> bc_valid && !bc_replay);
    // R6
    replay_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_has_tok && cmp_late |=> bc_replay && replay_regs == $past(hold_regs));
    // R7
    squash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && !cmp_has_tok && cmp_is_load && cmp_late |=> squash && !bc_valid);
endmodule

// File: rtl/tok_replay_tracker.sv
module tok_replay_tracker #(
    parameter int NTOK   = tok_pkg::NTOK_DEF,
    parameter int NREG   = tok_pkg::NREG_DEF,
    parameter int PCW    = tok_pkg::PCW_DEF,
    parameter int PDEPTH = tok_pkg::PDEPTH_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PCW-1:0]          pred_pc_i,
    output logic                    pred_miss_o,
    input  logic                    ren_valid_i,
    input  logic                    ren_flag_i,
    input  logic [$clog2(NREG)-1:0] ren_src_a_i,
    input  logic [$clog2(NREG)-1:0] ren_src_b_i,
    input  logic [$clog2(NREG)-1:0] ren_dst_i,
    input  logic                    ren_dst_we_i,
    output logic [NTOK-1:0]         ren_vec_o,
    output logic                    ren_tok_ok_o,
    output logic [$clog2(NTOK)-1:0] ren_tok_id_o,
    input  logic                    cmp_valid_i,
    input  logic                    cmp_is_load_i,
    input  logic [PCW-1:0]          cmp_pc_i,
    input  logic                    cmp_has_tok_i,
    input  logic [$clog2(NTOK)-1:0] cmp_tok_i,
    input  logic                    cmp_late_i,
    output logic                    bc_valid_o,
    output logic                    bc_replay_o,
    output logic [NTOK-1:0]         bc_mask_o,
    output logic [NREG-1:0]         replay_regs_o,
    output logic                    squash_o
);
    logic            head_done;
    logic [NREG-1:0] hold_regs;

    assign head_done = cmp_valid_i && cmp_has_tok_i;

    tok_miss_pred #(.PCW(PCW), .DEPTH(PDEPTH)) pred_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_pc   (pred_pc_i),
        .look_miss (pred_miss_o),
        .upd_en    (cmp_valid_i && cmp_is_load_i),
        .upd_pc    (cmp_pc_i),
        .upd_miss  (cmp_late_i)
    );

    tok_pool #(.NTOK(NTOK)) pool_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (ren_valid_i && ren_flag_i),
        .alloc_ok  (ren_tok_ok_o),
        .alloc_id  (ren_tok_id_o),
        .rel_en    (head_done),
        .rel_id    (cmp_tok_i)
    );

    tok_vec_table #(.NREG(NREG), .NTOK(NTOK)) table_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a      (ren_src_a_i),
        .rd_b      (ren_src_b_i),
        .own_en    (ren_tok_ok_o),
        .own_id    (ren_tok_id_o),
        .wr_en     (ren_valid_i && ren_dst_we_i),
        .wr_idx    (ren_dst_i),
        .clr_en    (head_done),
        .clr_id    (cmp_tok_i),
        .merged    (ren_vec_o),
        .hold_regs (hold_regs)
    );

    tok_bc_fsm #(.NREG(NREG), .NTOK(NTOK)) fsm_u (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_valid   (cmp_valid_i),
        .cmp_is_load (cmp_is_load_i),
        .cmp_has_tok (cmp_has_tok_i),
        .cmp_late    (cmp_late_i),
        .cmp_tok     (cmp_tok_i),
        .hold_regs   (hold_regs),
        .bc_valid    (bc_valid_o),
        .bc_replay   (bc_replay_o),
        .bc_mask     (bc_mask_o),
        .replay_regs (replay_regs_o),
        .squash      (squash_o)
    );

    // R8
    same_cycle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_done && ren_valid_i |-> !ren_vec_o[cmp_tok_i]);
endmodule

// File: tb/tok_replay_tracker_tb.sv
module tok_replay_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pred_pc_i;
    logic        pred_miss_o;
    logic        ren_valid_i, ren_flag_i, ren_dst_we_i;
    logic [3:0]  ren_src_a_i, ren_src_b_i, ren_dst_i;
    logic [7:0]  ren_vec_o;
    logic        ren_tok_ok_o;
    logic [2:0]  ren_tok_id_o;
    logic        cmp_valid_i, cmp_is_load_i, cmp_has_tok_i, cmp_late_i;
    logic [15:0] cmp_pc_i;
    logic [2:0]  cmp_tok_i;
    logic        bc_valid_o, bc_replay_o, squash_o;
    logic [7:0]  bc_mask_o;
    logic [15:0] replay_regs_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tok_replay_tracker dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        ren_valid_i = 0; ren_flag_i = 0; ren_dst_we_i = 0;
        ren_src_a_i = 0; ren_src_b_i = 0; ren_dst_i = 0;
        cmp_valid_i = 0; cmp_is_load_i = 0; cmp_has_tok_i = 0; cmp_late_i = 0;
        cmp_pc_i = 16'h0100; cmp_tok_i = 0;
    endtask

    task automatic idle_cycle();
        @(negedge clk); idle_in(); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); idle_in(); rst_n = 0; pred_pc_i = 16'h0010;
        repeat (2) @(negedge clk);
        rst_n = 1; #1;
    endtask

    task automatic ren(input logic fl, input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] d, input logic we);
        @(negedge clk); idle_in();
        ren_valid_i = 1; ren_flag_i = fl; ren_src_a_i = a; ren_src_b_i = b;
        ren_dst_i = d; ren_dst_we_i = we; #1;
    endtask

    task automatic cmp(input logic ld, input logic ht, input logic [2:0] t,
                       input logic late, input logic [15:0] pc);
        @(negedge clk); idle_in();
        cmp_valid_i = 1; cmp_is_load_i = ld; cmp_has_tok_i = ht; cmp_tok_i = t;
        cmp_late_i = late; cmp_pc_i = pc; #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bc_valid", bc_valid_o, 0);
        chk("R1 squash", squash_o, 0);
        chk("R1 pred_miss", pred_miss_o, 0);
        ren(0, 4'd3, 4'd9, 4'd0, 0);
        chk("R1 vector zero", ren_vec_o, 0);
        ren(1, 4'd0, 4'd0, 4'd1, 0);
        chk("R1 token0 free", {ren_tok_ok_o, ren_tok_id_o}, {1'b1, 3'd0});
        idle_cycle();
    endtask

    // R2: pc 0x0010 hashes to index 1, pc 0x0020 to index 2
    task automatic t_pred();
        do_reset();
        pred_pc_i = 16'h0010;
        cmp(1, 0, 0, 1, 16'h0010); idle_cycle();
        chk("R2 up to 2", pred_miss_o, 1);
        cmp(1, 0, 0, 1, 16'h0010); cmp(1, 0, 0, 1, 16'h0010);
        cmp(1, 0, 0, 0, 16'h0010); idle_cycle();
        chk("R2 saturate then 2", pred_miss_o, 1);
        cmp(1, 0, 0, 0, 16'h0010); idle_cycle();
        chk("R2 down to 1", pred_miss_o, 0);
        cmp(1, 0, 0, 0, 16'h0010); cmp(1, 0, 0, 0, 16'h0010);
        cmp(1, 0, 0, 1, 16'h0010); idle_cycle();
        chk("R2 low saturate", pred_miss_o, 0);
        pred_pc_i = 16'h0020; #1;
        chk("R2 other index", pred_miss_o, 0);
        pred_pc_i = 16'h0010;
    endtask

    // R4 R5 R6 chain: ld r1; ld r2; r3=r1|r2; r4=r3|r0; r5=r6|r7
    task automatic t_chain();
        do_reset();
        ren(1, 4'd4, 4'd4, 4'd1, 1);
        chk("R3 tok0", {ren_tok_ok_o, ren_tok_id_o}, {1'b1, 3'd0});
        chk("R4 own bit", ren_vec_o, 8'h01);
        ren(1, 4'd4, 4'd4, 4'd2, 1);
        chk("R3 tok1", ren_tok_id_o, 3'd1);
        ren(0, 4'd1, 4'd2, 4'd3, 1);
        chk("R4 merge", ren_vec_o, 8'h03);
        chk("R4 no tok", ren_tok_ok_o, 0);
        ren(0, 4'd3, 4'd0, 4'd4, 1);
        chk("R4 transitive", ren_vec_o, 8'h03);
        ren(0, 4'd6, 4'd7, 4'd5, 1);
        chk("R4 independent", ren_vec_o, 8'h00);
        cmp(1, 1, 3'd0, 0, 16'h0100);
        idle_cycle();
        chk("R5 valid", bc_valid_o, 1);
        chk("R5 clear kind", bc_replay_o, 0);
        chk("R5 mask", bc_mask_o, 8'h01);
        ren(0, 4'd3, 4'd1, 4'd0, 0);
        chk("R5 bit cleared", ren_vec_o, 8'h02);
        chk("R5 pulse over", bc_valid_o, 0);
        cmp(1, 1, 3'd1, 1, 16'h0100);
        idle_cycle();
        chk("R6 replay kind", {bc_valid_o, bc_replay_o}, 2'b11);
        chk("R6 mask", bc_mask_o, 8'h02);
        chk("R6 regs", replay_regs_o, 16'h001C);
        ren(0, 4'd4, 4'd2, 4'd0, 0);
        chk("R6 bit cleared", ren_vec_o, 8'h00);
    endtask

    task automatic t_squash();
        do_reset();
        ren(1, 4'd0, 4'd0, 4'd1, 1);
        cmp(1, 0, 3'd0, 1, 16'h0200);
        idle_cycle();
        chk("R7 squash", squash_o, 1);
        chk("R7 no broadcast", bc_valid_o, 0);
        ren(0, 4'd1, 4'd1, 4'd0, 0);
        chk("R7 vector kept", ren_vec_o, 8'h01);
        chk("R7 pulse one cycle", squash_o, 0);
        cmp(1, 0, 3'd0, 0, 16'h0200);
        idle_cycle();
        chk("R7 on-time no squash", squash_o, 0);
    endtask

    task automatic t_exhaust();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            ren(1, 4'd0, 4'd0, 4'(i + 1), 1);
            chk("R3 lowest free", {ren_tok_ok_o, ren_tok_id_o}, {1'b1, 3'(i)});
        end
        ren(1, 4'd0, 4'd0, 4'd10, 1);
        chk("R3 none free", ren_tok_ok_o, 0);
        chk("R3 no own bit", ren_vec_o, 8'h00);
        @(negedge clk); idle_in();
        cmp_valid_i = 1; cmp_is_load_i = 1; cmp_has_tok_i = 1; cmp_tok_i = 3'd5;
        ren_valid_i = 1; ren_flag_i = 1; ren_src_a_i = 4'd6; ren_src_b_i = 4'd2;
        ren_dst_i = 4'd11; ren_dst_we_i = 1; #1;
        chk("R9 not same cycle", ren_tok_ok_o, 0);
        chk("R8 masked merge", ren_vec_o, 8'h02);
        ren(1, 4'd0, 4'd0, 4'd12, 1);
        chk("R9 regrant", {ren_tok_ok_o, ren_tok_id_o}, {1'b1, 3'd5});
        chk("R5 clear of tok5", bc_mask_o, 8'h20);
        ren(0, 4'd11, 4'd11, 4'd0, 0);
        chk("R8 written value", ren_vec_o, 8'h02);
        ren(0, 4'd6, 4'd6, 4'd0, 0);
        chk("R5 r6 cleared", ren_vec_o, 8'h00);
        idle_cycle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_in(); rst_n = 0; pred_pc_i = 16'h0010;
        t_reset();
        t_pred();
        t_chain();
        t_squash();
        t_exhaust();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule